// File: doc/BRIEF.md
# PCI Interrupt Router and Trigger Stage

This block takes interrupt events from PCI devices, identified by the slot they sit in and the pin index (0 to 3) they raise, and turns each into an internal interrupt number. The number comes from a fixed slot plan. One slot shares four lines among its functions. Two slots each own a single line whatever pin they use. A group of expansion slots rotates its pins across a run of consecutive lines. Any other slot is passed through unmapped.

For a routed number inside the configured window, the block picks one bit from each of two configuration words, an edge-select word and a polarity word. The bit index is the routed number minus the base. With edge-select set, the event gives a single-cycle pulse on the CPU interrupt output. Otherwise the output is driven to the polarity bit, and the level the device reported is not used. Events are taken on a strobe. The routed number and the interrupt output are both registered.

Top module: `irq_route_top`

## Requirements
- R1: After reset, `cpu_irq` is 0 and `route_num` is 0.
- R2: A strobed event from slot 5 with pin p routes to number 32 + p, and `route_num` shows it one cycle after the strobe.
- R3: Slot 6 routes to 36 and slot 7 routes to 37, for every pin.
- R4: Slots 8 to 12 route pin p to 38 + (slot - 8) + p, so slot 12 pin 3 gives 45.
- R5: Any other slot routes to the pin index itself (0 to 3).
- R6: When the routed number n lies in 32..63 and bit n-32 of `edge_cfg` is 1, `cpu_irq` is 1 in the cycle after the strobe and 0 in the cycle after that, unless another pulsing event is strobed.
- R7: When n lies in 32..63 and bit n-32 of `edge_cfg` is 0, `cpu_irq` takes the value of bit n-32 of `pol_cfg` from the cycle after the strobe and keeps it until a later event.
- R8: An event routed below 32 leaves `cpu_irq` unchanged, except that a pulse still in progress ends as it would without the event.
- R9: The value on `evt_level` has no effect on `cpu_irq` or `route_num`.
- R10: `edge_cfg` and `pol_cfg` are read only on a strobe. A change without a strobe leaves `cpu_irq` unchanged.
- R11: Pulsing events strobed on consecutive cycles keep `cpu_irq` at 1 for each of those cycles. The output falls one cycle after the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Strobe: an interrupt event is present this cycle |
| evt_slot | input | 5 | Slot number of the device raising the event |
| evt_pin | input | 2 | Interrupt pin index 0 to 3 |
| evt_level | input | 1 | Line level reported with the event (not used for the output) |
| edge_cfg | input | 32 | Per-line edge-select bits, indexed by routed number minus 32 |
| pol_cfg | input | 32 | Per-line polarity bits used in level mode |
| route_num | output | 7 | Routed number of the last strobed event |
| cpu_irq | output | 1 | Interrupt output to the CPU |

## Verification
Two trigger functions can land on the output in the same cycle. The first is the end of a pulse raised by the previous event. The second is the action of a newly strobed event, which may be another pulse, a level setting or an ignored pass-through. The bench provokes each pairing by strobing the second event on the cycle right after a pulsing one. It then judges the pairing by the output in the next cycle: 1 for a new pulse, the polarity bit for a level line, and 0 when a pass-through event meets an ending pulse.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // What a strobed event does to the CPU interrupt output
  typedef enum logic [1:0] {
    TRIG_IGNORE = 2'd0,
    TRIG_PULSE  = 2'd1,
    TRIG_LEVEL  = 2'd2
  } trig_action_e;

endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map #(
  parameter int SLOT_W      = 5,
  parameter int NUM_W       = 7,
  parameter int IRQ_BASE    = 32,
  parameter int SHARED_SLOT = 5,
  parameter int GFX_SLOT    = 6,
  parameter int NIC_SLOT    = 7,
  parameter int EXP_FIRST   = 8,
  parameter int EXP_COUNT   = 5,
  parameter int FIXED_LINES = 6
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [1:0]        pin,
  output logic [NUM_W-1:0]  num
);

  localparam int EXP_LAST = EXP_FIRST + EXP_COUNT - 1;

  // Slot plan arithmetic in integer form
  function automatic logic [NUM_W-1:0] route_calc(input logic [SLOT_W-1:0] s_in,
                                                  input logic [1:0] p_in);
    int s;
    int p;
    int r;
    s = int'(s_in);
    p = int'(p_in);
    if (s == SHARED_SLOT)
      r = IRQ_BASE + (p % 4);
    else if (s == GFX_SLOT)
      r = IRQ_BASE + FIXED_LINES - 2;
    else if (s == NIC_SLOT)
      r = IRQ_BASE + FIXED_LINES - 1;
    else if (s >= EXP_FIRST && s <= EXP_LAST)
      r = IRQ_BASE + FIXED_LINES + (s - EXP_FIRST) + p;
    else
      r = p;
    return NUM_W'(r);
  endfunction

  assign num = route_calc(slot, pin);

endmodule

// File: rtl/irq_trigger.sv
module irq_trigger
  import irq_route_pkg::*;
#(
  parameter int NUM_W    = 7,
  parameter int IRQ_BASE = 32,
  parameter int CFG_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NUM_W-1:0] num,
  input  logic [CFG_W-1:0] edge_cfg,
  input  logic [CFG_W-1:0] pol_cfg,
  output logic             irq_out
);

  localparam int IDX_W = (CFG_W > 1) ? $clog2(CFG_W) : 1;
  localparam logic [NUM_W:0] LOW_N  = (NUM_W+1)'(IRQ_BASE);
  localparam logic [NUM_W:0] HIGH_N = (NUM_W+1)'(IRQ_BASE + CFG_W);

  // Named internal events, used by the assertions below
  logic             in_window;
  logic [IDX_W-1:0] cfg_idx;
  logic             level_val;
  trig_action_e     action;
  logic             fire_pulse;
  logic             fire_level;
  logic             pulse_q;

  function automatic logic [IDX_W-1:0] index_of(input logic [NUM_W-1:0] n);
    logic [NUM_W:0] d;
    d = {1'b0, n} - LOW_N;
    return d[IDX_W-1:0];
  endfunction

  always_comb begin
    in_window = ({1'b0, num} >= LOW_N) && ({1'b0, num} < HIGH_N);
    cfg_idx   = index_of(num);
    level_val = pol_cfg[cfg_idx];
    if (!in_window)
      action = TRIG_IGNORE;
    else if (edge_cfg[cfg_idx])
      action = TRIG_PULSE;
    else
      action = TRIG_LEVEL;
  end

  assign fire_pulse = load && (action == TRIG_PULSE);
  assign fire_level = load && (action == TRIG_LEVEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_out <= 1'b0;
      pulse_q <= 1'b0;
    end else if (fire_pulse) begin
      irq_out <= 1'b1;
      pulse_q <= 1'b1;
    end else if (fire_level) begin
      irq_out <= level_val;
      pulse_q <= 1'b0;
    end else if (pulse_q) begin
      irq_out <= 1'b0;
      pulse_q <= 1'b0;
    end
  end

  // A pulsing event raises the output in the next cycle (R6, R11)
  assert_pulse_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_pulse |=> irq_out);

  // A pulse with nothing following it drops after one cycle (R6, R8)
  assert_pulse_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && !fire_pulse && !fire_level) |=> !irq_out);

  // A level event copies the sampled polarity bit (R7)
  assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_level |=> (irq_out == $past(level_val)));

  // No event and no pulse in flight: output holds (R10)
  assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_pulse && !fire_level && !pulse_q) |=> $stable(irq_out));

  // Pulse flag only ever set together with a high output (R6)
  assert_flag_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> irq_out);

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top #(
  parameter int SLOT_W   = 5,
  parameter int IRQ_BASE = 32,
  parameter int CFG_W    = 32,
  parameter int NUM_W    = $clog2(IRQ_BASE + CFG_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [SLOT_W-1:0] evt_slot,
  input  logic [1:0]        evt_pin,
  input  logic              evt_level,
  input  logic [CFG_W-1:0]  edge_cfg,
  input  logic [CFG_W-1:0]  pol_cfg,
  output logic [NUM_W-1:0]  route_num,
  output logic              cpu_irq
);

  logic [NUM_W-1:0] mapped_num;
  logic             unused_level;

  // The reported level is not part of the trigger decision
  assign unused_level = evt_level;

  irq_slot_map #(
    .SLOT_W   (SLOT_W),
    .NUM_W    (NUM_W),
    .IRQ_BASE (IRQ_BASE)
  ) u_map (
    .slot (evt_slot),
    .pin  (evt_pin),
    .num  (mapped_num)
  );

  irq_trigger #(
    .NUM_W    (NUM_W),
    .IRQ_BASE (IRQ_BASE),
    .CFG_W    (CFG_W)
  ) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (evt_valid),
    .num      (mapped_num),
    .edge_cfg (edge_cfg),
    .pol_cfg  (pol_cfg),
    .irq_out  (cpu_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      route_num <= '0;
    else if (evt_valid)
      route_num <= mapped_num;
  end

  // Single-line slots ignore the pin (R3)
  assert_fixed_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (int'(evt_slot) == 6)) |=> (int'(route_num) == IRQ_BASE + 4));

  // Routed number changes only on a strobe (R2)
  assert_route_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> $stable(route_num));

endmodule

// File: tb/irq_route_top_test.sv
`timescale 1ns/1ps
module irq_route_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [4:0]  evt_slot = '0;
  logic [1:0]  evt_pin = '0;
  logic        evt_level = 1'b0;
  logic [31:0] edge_cfg = '0;
  logic [31:0] pol_cfg = '0;
  logic [6:0]  route_num;
  logic        cpu_irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  irq_route_top uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_slot(evt_slot),
    .evt_pin(evt_pin), .evt_level(evt_level), .edge_cfg(edge_cfg),
    .pol_cfg(pol_cfg), .route_num(route_num), .cpu_irq(cpu_irq)
  );

  // Expected routing, written from the slot plan
  function automatic int expect_route(int slot, int pin);
    case (slot)
      5:       return 32 + pin;
      6:       return 36;
      7:       return 37;
      8, 9, 10, 11, 12: return 38 + slot - 8 + pin;
      default: return pin;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Strobe one event; returns at the negedge after the capturing edge
  task automatic strobe(int slot, int pin, logic lvl);
    @(negedge clk);
    evt_slot  = 5'(slot);
    evt_pin   = 2'(pin);
    evt_level = lvl;
    evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic settle_low();
    edge_cfg = '0; pol_cfg = '0;
    strobe(5, 0, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 irq", cpu_irq, 0);
    check("R1 route", route_num, 0);
  endtask

  task automatic t_shared_slot();
    for (int p = 0; p < 4; p++) begin
      strobe(5, p, 1'b0);
      check("R2 route", route_num, expect_route(5, p));
    end
  endtask

  task automatic t_fixed_slots();
    for (int p = 0; p < 4; p++) begin
      strobe(6, p, 1'b1);
      check("R3 slot6", route_num, 36);
      strobe(7, p, 1'b0);
      check("R3 slot7", route_num, 37);
    end
  endtask

  task automatic t_expansion();
    for (int s = 8; s <= 12; s++)
      for (int p = 0; p < 4; p++) begin
        strobe(s, p, 1'b0);
        check("R4 route", route_num, expect_route(s, p));
      end
  endtask

  task automatic t_passthrough();
    strobe(3, 2, 1'b0);
    check("R5 slot3", route_num, 2);
    strobe(13, 1, 1'b0);
    check("R5 slot13", route_num, 1);
    strobe(0, 3, 1'b0);
    check("R5 slot0", route_num, 3);
  endtask

  task automatic t_edge_pulse();
    settle_low();
    edge_cfg = 32'h1 << 2;          // slot5 pin2 -> 34 -> bit 2
    strobe(5, 2, 1'b0);
    check("R6 pulse high", cpu_irq, 1);
    @(negedge clk);
    check("R6 pulse low", cpu_irq, 0);
    @(negedge clk);
    check("R6 stays low", cpu_irq, 0);
  endtask

  task automatic t_level();
    settle_low();
    pol_cfg = 32'h1 << 4;           // slot6 -> 36 -> bit 4
    strobe(6, 1, 1'b0);
    check("R7 level high", cpu_irq, 1);
    repeat (3) @(negedge clk);
    check("R7 level held", cpu_irq, 1);
    strobe(7, 0, 1'b1);             // 37 -> bit 5 clear
    check("R7 level low", cpu_irq, 0);
    pol_cfg = 32'h1 << 15;          // slot12 pin3 -> 45 -> bit 13? 45-32=13
    pol_cfg = 32'h1 << 13;
    strobe(12, 3, 1'b0);
    check("R7 top line", cpu_irq, 1);
  endtask

  task automatic t_ignore();
    settle_low();
    pol_cfg = 32'h1 << 11;          // slot10 pin3 -> 43 -> bit 11
    strobe(10, 3, 1'b0);
    check("R7 exp level", cpu_irq, 1);
    pol_cfg = '0; edge_cfg = '1;
    strobe(3, 1, 1'b0);
    check("R8 hold high", cpu_irq, 1);
    // pulse ending in the same cycle as a pass-through event
    edge_cfg = 32'h1;
    strobe(5, 0, 1'b0);
    check("R8 pulse up", cpu_irq, 1);
    evt_slot = 5'd20; evt_pin = 2'd0; evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
    check("R8 pulse ends", cpu_irq, 0);
  endtask

  task automatic t_level_input();
    settle_low();
    pol_cfg = 32'h1 << 5;
    strobe(7, 2, 1'b0);
    check("R9 lvl0 irq", cpu_irq, 1);
    strobe(7, 2, 1'b1);
    check("R9 lvl1 irq", cpu_irq, 1);
    check("R9 route", route_num, 37);
    pol_cfg = '0;
    strobe(7, 2, 1'b1);
    check("R9 pol low", cpu_irq, 0);
  endtask

  task automatic t_cfg_sampling();
    settle_low();
    pol_cfg = 32'h1 << 4;
    strobe(6, 0, 1'b0);
    check("R10 setup", cpu_irq, 1);
    pol_cfg = '0;
    repeat (3) @(negedge clk);
    check("R10 no strobe", cpu_irq, 1);
    edge_cfg = '1;
    @(negedge clk);
    check("R10 edge change", cpu_irq, 1);
  endtask

  task automatic t_back_to_back();
    settle_low();
    edge_cfg = 32'h1 << 6;          // slot8 pin0 -> 38 -> bit 6
    @(negedge clk);
    evt_slot = 5'd8; evt_pin = 2'd0; evt_valid = 1'b1;
    @(negedge clk);
    check("R11 first", cpu_irq, 1);
    @(negedge clk);
    check("R11 second", cpu_irq, 1);
    @(negedge clk);
    evt_valid = 1'b0;
    check("R11 third", cpu_irq, 1);
    @(negedge clk);
    check("R11 fall", cpu_irq, 0);
    // pulse followed at once by a level event with polarity set
    edge_cfg = 32'h1 << 6; pol_cfg = 32'h1 << 4;
    strobe(8, 0, 1'b0);
    check("R11 pulse", cpu_irq, 1);
    strobe(6, 0, 1'b0);
    check("R7 after pulse", cpu_irq, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shared_slot();
    t_fixed_slots();
    t_expansion();
    t_passthrough();
    t_edge_pulse();
    t_level();
    t_ignore();
    t_level_input();
    t_cfg_sampling();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule